// File: doc/BRIEF.md
# PHY Receive Error Statistics Counters

This block keeps five independent 16-bit event counters that a PHY's management register space exposes as read-only statistics. They record link disconnects, 100BASE-TX frames that contained a receive error, receive symbol errors, 100BASE-TX premature end-of-frame events and 10BASE-T end-of-frame errors. The receive path supplies single-cycle strobes together with a start-of-frame marker and a per-cycle symbol-valid/symbol-bad pair. The block derives two of the counts itself: it allows at most one frame-error count per frame, and it groups runs of consecutive bad symbols six to one.

Software reaches the counters through a plain register access port that carries a 5-bit register number. Every counter saturates at its all-ones value rather than wrapping. Reading a counter returns its value and then resets it to zero, so each read yields the events seen since the previous read. Write accesses leave every counter untouched.

Top module: `phy_rx_err_stats`

## Requirements
- R1: After reset every counter reads as zero and `rd_data_o` is zero.
- R2: A counter that has reached 0xFFFF stays at 0xFFFF under further events until it is read.
- R3: A read access (`acc_en_i`=1, `acc_we_i`=0) puts the selected counter's value on `rd_data_o` one clock later. The register numbers are 20 for disconnects, 21 for frames with errors, 22 for symbol errors, 23 for premature end-of-frame and 24 for 10BASE-T end-of-frame errors. `rd_data_o` holds its value between read accesses.
- R4: A read of register 20 to 24 resets the counter it selects to zero and leaves the other counters unchanged.
- R5: A write access (`acc_en_i`=1, `acc_we_i`=1) changes no counter and does not change `rd_data_o`.
- R6: Register 21 adds one for the first error condition in a frame and ignores any further ones until the next `sof_i`. An error condition is a cycle with `sym_valid_i`=1 and `sym_bad_i`=1, or a cycle with `early_end_i`=1. An error in the same cycle as `sof_i` belongs to the new frame.
- R7: Register 22 adds one on the first bad symbol of each group of six consecutive bad symbols, so a run of 1–6 adds one and a run of 7–12 adds two. A valid good symbol or `sof_i` (which also applies to a symbol in its own cycle) restarts the group. Cycles with `sym_valid_i`=0 leave the group position unchanged.
- R8: Registers 20, 23 and 24 each add one for every cycle in which `link_drop_i`, `early_end_i` or `t10_eof_err_i` respectively is high.
- R9: When an event and a read of the same counter fall in the same cycle, the read returns the old value and the counter then holds 1.
- R10: A read of a register number outside 20–24 returns zero and clears no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| link_drop_i | input | 1 | Disconnect event strobe |
| sof_i | input | 1 | Start-of-frame marker from the 100BASE-TX receive path |
| sym_valid_i | input | 1 | A received symbol is present this cycle |
| sym_bad_i | input | 1 | The present symbol is invalid |
| early_end_i | input | 1 | 100BASE-TX premature end-of-frame strobe |
| t10_eof_err_i | input | 1 | 10BASE-T end-of-frame error strobe |
| acc_en_i | input | 1 | Register access request |
| acc_we_i | input | 1 | Access is a write (ignored) |
| acc_addr_i | input | 5 | Register number |
| rd_data_o | output | 16 | Read data, valid the cycle after a read |

## Verification
The bad-symbol grouping is tried with a run of seven followed by a good symbol and a run of two, which separates modulo-six grouping from a plain count. A run of six interrupted by cycles with no valid symbol shows that idle cycles do not restart a group. The frame rule is tried with repeated error conditions inside one frame and with errors that arrive in the same cycle as `sof_i`, which shows where frame ownership changes. Strobe bursts followed by reads show whether reads clear the counters. A read that coincides with an event, reads of register numbers outside the range and a burst of more than 65535 events cover the clearing, decoding and saturation corners.

// File: rtl/phy_rx_stats_pkg.sv
package phy_rx_stats_pkg;

  // Width of every statistics counter
  parameter int STAT_W = 16;

  // Number of counters in the bank
  parameter int NUM_STATS = 5;

  // Counter slot order; slot k sits at register number BASE + k
  typedef enum logic [2:0] {
    SLOT_LINK_DROP = 3'd0,
    SLOT_ERR_FRAME = 3'd1,
    SLOT_BAD_SYM   = 3'd2,
    SLOT_EARLY_END = 3'd3,
    SLOT_T10_EOF   = 3'd4
  } stat_slot_e;

  // Saturating increment: the all-ones value is sticky
  function automatic logic [STAT_W-1:0] sat_bump(input logic [STAT_W-1:0] v);
    return (&v) ? v : v + STAT_W'(1);
  endfunction

  // Value a counter takes on a read-clear, given a coincident event
  function automatic logic [STAT_W-1:0] clear_value(input logic ev);
    return ev ? STAT_W'(1) : '0;
  endfunction

endpackage

// File: rtl/phy_stat_sat_cnt.sv
module phy_stat_sat_cnt
  import phy_rx_stats_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] cnt_o,
  output logic              full_o
);

  logic [STAT_W-1:0] cnt_q;
  logic [STAT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = clear_value(inc_i);
    end else if (inc_i) begin
      cnt_d = sat_bump(cnt_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;

endmodule

// File: rtl/phy_rx_err_grouper.sv
module phy_rx_err_grouper #(
  parameter int GROUP_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic sym_valid_i,
  input  logic sym_bad_i,
  input  logic early_end_i,
  output logic sym_inc_o,
  output logic frame_inc_o,
  output logic frame_flag_o
);

  localparam int RUN_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GROUP_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d, run_eff;
  logic             flag_q, flag_d, flag_eff;
  logic             bad_sym;
  logic             err_cond;

  // A start-of-frame applies to the symbol in the same cycle
  assign run_eff  = sof_i ? '0 : run_q;
  assign flag_eff = sof_i ? 1'b0 : flag_q;

  assign bad_sym  = sym_valid_i & sym_bad_i;
  assign err_cond = bad_sym | early_end_i;

  // First bad symbol of each group contributes one count
  assign sym_inc_o = bad_sym && (run_eff == '0);

  always_comb begin
    run_d = run_eff;
    if (bad_sym) begin
      run_d = (run_eff == RUN_LAST) ? '0 : run_eff + RUN_W'(1);
    end else if (sym_valid_i) begin
      run_d = '0;
    end
  end

  assign frame_inc_o = err_cond & ~flag_eff;
  assign flag_d      = flag_eff | err_cond;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign frame_flag_o = flag_q;

endmodule

// File: rtl/phy_stat_rd_port.sv
module phy_stat_rd_port
  import phy_rx_stats_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 20
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              acc_en_i,
  input  logic                              acc_we_i,
  input  logic [ADDR_W-1:0]                 acc_addr_i,
  input  logic [NUM_STATS-1:0][STAT_W-1:0]  cnt_all_i,
  output logic [NUM_STATS-1:0]              clr_o,
  output logic                              hit_o,
  output logic [STAT_W-1:0]                 rd_data_o
);

  localparam int LAST_ADDR = BASE_ADDR + NUM_STATS - 1;

  logic              rd_req;
  logic [STAT_W-1:0] sel_val;
  logic [STAT_W-1:0] rd_q;

  assign rd_req = acc_en_i & ~acc_we_i;
  assign hit_o  = (int'(acc_addr_i) >= BASE_ADDR) && (int'(acc_addr_i) <= LAST_ADDR);

  // One decoder per slot
  for (genvar k = 0; k < NUM_STATS; k++) begin : g_dec
    assign clr_o[k] = rd_req && (int'(acc_addr_i) == BASE_ADDR + k);
  end

  always_comb begin
    sel_val = '0;
    for (int k = 0; k < NUM_STATS; k++) begin
      if (clr_o[k]) sel_val = cnt_all_i[k];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_req) begin
      rd_q <= sel_val;
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/phy_rx_err_stats.sv
module phy_rx_err_stats
  import phy_rx_stats_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 20,
  parameter int GROUP_LEN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_drop_i,
  input  logic              sof_i,
  input  logic              sym_valid_i,
  input  logic              sym_bad_i,
  input  logic              early_end_i,
  input  logic              t10_eof_err_i,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [STAT_W-1:0] rd_data_o
);

  // Named internal events, visible to the bound checker
  logic                             sym_inc;
  logic                             frame_inc;
  logic                             frame_flag;
  logic                             rd_hit;
  logic [NUM_STATS-1:0]             inc_vec;
  logic [NUM_STATS-1:0]             clr_vec;
  logic [NUM_STATS-1:0]             full_vec;
  logic [NUM_STATS-1:0][STAT_W-1:0] cnt_all;

  phy_rx_err_grouper #(
    .GROUP_LEN (GROUP_LEN)
  ) grp_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof_i),
    .sym_valid_i  (sym_valid_i),
    .sym_bad_i    (sym_bad_i),
    .early_end_i  (early_end_i),
    .sym_inc_o    (sym_inc),
    .frame_inc_o  (frame_inc),
    .frame_flag_o (frame_flag)
  );

  always_comb begin
    inc_vec                 = '0;
    inc_vec[SLOT_LINK_DROP] = link_drop_i;
    inc_vec[SLOT_ERR_FRAME] = frame_inc;
    inc_vec[SLOT_BAD_SYM]   = sym_inc;
    inc_vec[SLOT_EARLY_END] = early_end_i;
    inc_vec[SLOT_T10_EOF]   = t10_eof_err_i;
  end

  for (genvar k = 0; k < NUM_STATS; k++) begin : g_cnt
    phy_stat_sat_cnt cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc_vec[k]),
      .clr_i  (clr_vec[k]),
      .cnt_o  (cnt_all[k]),
      .full_o (full_vec[k])
    );
  end

  phy_stat_rd_port #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) rd_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_en_i   (acc_en_i),
    .acc_we_i   (acc_we_i),
    .acc_addr_i (acc_addr_i),
    .cnt_all_i  (cnt_all),
    .clr_o      (clr_vec),
    .hit_o      (rd_hit),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: rtl/phy_rx_err_stats_chk.sv
module phy_rx_err_stats_chk
  import phy_rx_stats_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 20
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             sof_i,
  input logic                             acc_en_i,
  input logic                             acc_we_i,
  input logic [ADDR_W-1:0]                acc_addr_i,
  input logic [STAT_W-1:0]                rd_data_o,
  input logic                             frame_inc,
  input logic                             frame_flag,
  input logic                             rd_hit,
  input logic [NUM_STATS-1:0]             inc_vec,
  input logic [NUM_STATS-1:0]             clr_vec,
  input logic [NUM_STATS-1:0]             full_vec,
  input logic [NUM_STATS-1:0][STAT_W-1:0] cnt_all
);

  logic              rd_req;
  logic [STAT_W-1:0] addr_val;

  assign rd_req = acc_en_i & ~acc_we_i;

  always_comb begin
    addr_val = '0;
    for (int k = 0; k < NUM_STATS; k++) begin
      if (int'(acc_addr_i) == BASE_ADDR + k) addr_val = cnt_all[k];
    end
  end

  // R3: read data is the addressed counter's value before the read
  a_r3_read_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && rd_hit |=> rd_data_o == $past(addr_val));

  // R3: read data holds between reads
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rd_data_o));

  // R10: outside the register range the read returns zero
  a_r10_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && !rd_hit |=> rd_data_o == '0);

  // R10 and R5: only an in-range read clears anything
  a_r5_r10_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req && rd_hit) |-> clr_vec == '0);

  // R6: no second frame-error count inside one frame
  a_r6_once_per_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_flag && !sof_i |-> !frame_inc);

  a_r4_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_vec));

  for (genvar k = 0; k < NUM_STATS; k++) begin : g_slot
    // R2: a full counter stays full until read
    a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_vec[k] && !clr_vec[k] |=> full_vec[k]);

    // R4: a read without a coincident event leaves zero
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vec[k] && !inc_vec[k] |=> cnt_all[k] == '0);

    // R9: a read that meets an event leaves one
    a_r9_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vec[k] && inc_vec[k] |=> cnt_all[k] == STAT_W'(1));

    // R8: no event and no read means no change
    a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_vec[k] && !inc_vec[k] |=> $stable(cnt_all[k]));
  end

endmodule

bind phy_rx_err_stats phy_rx_err_stats_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sof_i      (sof_i),
  .acc_en_i   (acc_en_i),
  .acc_we_i   (acc_we_i),
  .acc_addr_i (acc_addr_i),
  .rd_data_o  (rd_data_o),
  .frame_inc  (frame_inc),
  .frame_flag (frame_flag),
  .rd_hit     (rd_hit),
  .inc_vec    (inc_vec),
  .clr_vec    (clr_vec),
  .full_vec   (full_vec),
  .cnt_all    (cnt_all)
);

// File: tb/phy_rx_err_stats_tb_top.sv
module phy_rx_err_stats_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int MAXV       = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_drop = 1'b0, sof = 1'b0, sv = 1'b0, sb = 1'b0;
  logic        early = 1'b0, t10 = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  int model [5];
  int run   = 0;
  bit flag  = 1'b0;
  int m_rd  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_rx_err_stats dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .link_drop_i   (link_drop),
    .sof_i         (sof),
    .sym_valid_i   (sv),
    .sym_bad_i     (sb),
    .early_end_i   (early),
    .t10_eof_err_i (t10),
    .acc_en_i      (acc_en),
    .acc_we_i      (acc_we),
    .acc_addr_i    (acc_addr),
    .rd_data_o     (rd_data)
  );

  // Reference model: events per cycle, read-clear, then saturating add
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (model[k]) model[k] = 0;
      run = 0; flag = 1'b0; m_rd = 0;
    end else begin
      bit ev [5];
      bit bad, err;
      int r;
      bit f;
      r   = sof ? 0 : run;
      f   = sof ? 1'b0 : flag;
      bad = sv && sb;
      err = bad || early;
      ev[0] = link_drop;
      ev[2] = bad && (r == 0);
      if (bad) r = (r + 1) % 6;
      else if (sv) r = 0;
      ev[1] = err && !f;
      f = f || err;
      ev[3] = early;
      ev[4] = t10;
      run = r; flag = f;
      if (acc_en && !acc_we) begin
        if (acc_addr >= 20 && acc_addr <= 24) begin
          m_rd = model[acc_addr - 20];
          model[acc_addr - 20] = 0;
        end else begin
          m_rd = 0;
        end
      end
      foreach (model[k]) if (ev[k] && model[k] < MAXV) model[k]++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference model (R3)
  always @(negedge clk) begin
    if (rst_n && !done) check("R3 per-cycle read data", int'(rd_data), m_rd);
  end

  task automatic summary();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic drive(input bit ld, input bit s, input bit v, input bit b,
                       input bit e, input bit t);
    @(negedge clk);
    link_drop = ld; sof = s; sv = v; sb = b; early = e; t10 = t;
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_read(input int addr, input bit ld, input int exp, input string tag);
    @(negedge clk);
    link_drop = ld; sof = 0; sv = 0; sb = 0; early = 0; t10 = 0;
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = 5'(addr);
    @(negedge clk);
    acc_en = 1'b0; link_drop = 0;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic do_write(input int addr);
    @(negedge clk);
    link_drop = 0; sof = 0; sv = 0; sb = 0; early = 0; t10 = 0;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 5'(addr);
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 read data after reset", int'(rd_data), 0);
    for (int a = 20; a <= 24; a++) do_read(a, 0, 0, "R1 counter zero after reset");

    // R8 disconnect strobes, R4 clear on read
    repeat (3) drive(1, 0, 0, 0, 0, 0);
    idle();
    do_read(20, 0, 3, "R8 disconnect count");
    do_read(20, 0, 0, "R4 cleared by read");

    // R7 run of 7, good symbol, run of 2
    drive(0, 1, 0, 0, 0, 0);
    repeat (7) drive(0, 0, 1, 1, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    repeat (2) drive(0, 0, 1, 1, 0, 0);
    idle();
    do_read(22, 0, 3, "R7 grouping of runs 7 and 2");
    do_read(21, 0, 1, "R6 one frame counted once");

    // R7 idle cycles inside a run do not restart the group
    drive(0, 1, 0, 0, 0, 0);
    repeat (3) drive(0, 0, 1, 1, 0, 0);
    repeat (2) idle();
    repeat (3) drive(0, 0, 1, 1, 0, 0);
    idle();
    do_read(22, 0, 1, "R7 run of six across idle cycles");
    do_read(21, 0, 1, "R6 single frame with many errors");

    // R6 frame ownership at sof, R8 premature end strobes
    drive(0, 1, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(0, 0, 1, 1, 0, 0);
    drive(0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(0, 1, 1, 1, 0, 0);
    idle();
    do_read(21, 0, 3, "R6 errors at sof belong to new frame");
    do_read(23, 0, 3, "R8 premature end count");
    do_read(22, 0, 2, "R7 sof restarts symbol group");

    // R8 10BASE-T end-of-frame errors
    repeat (5) drive(0, 0, 0, 0, 0, 1);
    idle();
    do_read(24, 0, 5, "R8 10BASE-T end-of-frame count");

    // R5 writes ignored
    repeat (2) drive(1, 0, 0, 0, 0, 0);
    idle();
    do_write(20);
    check("R5 write leaves read data", int'(rd_data), 5);
    do_read(20, 0, 2, "R5 write leaves counter");

    // R10 out-of-range reads
    drive(1, 0, 0, 0, 0, 0);
    idle();
    do_read(19, 0, 0, "R10 address 19 reads zero");
    do_read(25, 0, 0, "R10 address 25 reads zero");
    do_read(31, 0, 0, "R10 address 31 reads zero");
    do_read(20, 0, 1, "R10 no clear by out-of-range read");

    // R9 read coinciding with an event
    repeat (4) drive(1, 0, 0, 0, 0, 0);
    do_read(20, 1, 4, "R9 collision returns old value");
    do_read(20, 0, 1, "R9 collision leaves one");

    // R2 saturation
    repeat (MAXV + 5) drive(1, 0, 0, 0, 0, 0);
    idle();
    do_read(20, 0, MAXV, "R2 saturates at 0xFFFF");
    do_read(20, 0, 0, "R2 saturated counter clears on read");

    repeat (2) idle();
    summary();
  end

endmodule